// File: doc/BRIEF.md
# Dual-Range Narrow Peripheral Bus Bridge

This block connects a 32-bit internal request port to a narrow external peripheral bus whose sixteen lines carry both address and data. Two programmable windows decide which internal addresses reach the external bus. Each window has its own base, size, data width (8 or 16 bits) and wait-state count. A request that falls in neither enabled window never touches the external bus and gets an error response.

Every 32-bit request is split into narrow beats: four byte beats in an 8-bit window, two halfword beats in a 16-bit window. Each beat has one address cycle, then the window's wait cycles, then one data cycle. Narrow data always travels on the low lanes, and the demultiplexed low address lines step from beat to beat. On a write every line stays driven through the wait and data cycles. In an 8-bit window the upper lanes keep carrying the upper byte of the beat address.

The requester holds `reqValid` and its fields steady until it sees `rspReady`. The block only takes a request while it is idle.

Top module: `narrowPeriphBridge`

## Requirements
- R1: Each window register is laid out as enable bit 0, width bit 1 (0 = 8-bit, 1 = 16-bit), wait count in bits 7:4, size exponent in bits 12:8 and base in bits 31:16. Unused bits read as zero. An address hits a window when it is enabled and the address equals {base,16'h0} above bit s, where s is the size exponent raised to at least 16. When both windows hit, window 0 wins. Bus cycles are never overlapping: at most one of busAle, busRd and busWr is high.
- R2: A request that hits no enabled window raises rspReady together with rspError for one cycle, and drives no address, read or write cycle.
- R3: In an 8-bit window a request takes 4 beats, with byte offsets 0, 1, 2 and 3. lowAddr[1:0] equals the beat number and lowAddr[2] is address bit 2. Data travels on adOut/adIn bits 7:0, and the least significant byte comes first.
- R4: In a 16-bit window a request takes 2 beats. lowAddr[2:1] carries the halfword offset, lowAddr[0] is 0, data travels on bits 15:0, and the low halfword comes first.
- R5: Each beat is one busAle cycle followed by N busRd or busWr wait cycles and one further data cycle, where N is the window's wait count. rspReady rises in the cycle right after the last data cycle. A request therefore occupies beats × (N + 2) bus cycles.
- R6: On a write adOe is high through every wait and data cycle. In an 8-bit window adOut[15:8] carries bits 15:8 of the beat address while the data byte is on bits 7:0.
- R7: During busAle, adOut carries bits 15:0 of the beat's byte address and adOe is high.
- R8: After reset both window registers read 32'h0000_00F0: disabled, 8-bit width, maximum wait count.
- R9: On a read adOe is low during every wait and data cycle, and rspRData holds the assembled 32-bit word while rspReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Write strobe for a window register |
| cfgSel | input | 1 | Window register select, for both write and readback |
| cfgWrData | input | 32 | Value written to the selected window register |
| cfgRdData | output | 32 | Contents of the selected window register |
| reqValid | input | 1 | Request present, held until rspReady |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Request byte address; bits 1:0 are ignored |
| reqWData | input | 32 | Write data |
| rspReady | output | 1 | One-cycle completion pulse |
| rspError | output | 1 | Miss indication, valid with rspReady |
| rspRData | output | 32 | Read data, valid with rspReady |
| busAle | output | 1 | Address cycle strobe |
| busRd | output | 1 | Read wait and data cycles |
| busWr | output | 1 | Write wait and data cycles |
| lowAddr | output | 3 | Demultiplexed low address lines |
| adOut | output | 16 | Values driven on the address/data lines |
| adOe | output | 1 | Output enable for adOut |
| adIn | input | 16 | Values received on the address/data lines |

## Verification
The hardest case to reach from the ports is two windows claiming the same address. To cover it, the stimulus widens window 1 until it covers window 0. It then issues requests that land in both windows and in window 1 alone. Finally it disables window 0 and repeats the shared address, which must fall through to the 16-bit window and show two beats instead of four. A second hard case is the maximum wait count. The bench reprograms a window to 15 waits and checks the full bus-cycle count of the request. A device model watches every 8-bit write cycle and compares the upper lanes against the latched beat address.

// File: rtl/npbPkg.sv
package npbPkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BUS_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_DATA,
    ST_RESP
  } npbState_e;

  typedef struct packed {
    logic       capture;
    logic       ale;
    logic       rd;
    logic       wr;
    logic       dataPh;
    logic       wide;
    logic [1:0] beat;
  } npbStrobe_t;
endpackage

// File: rtl/npbCtrl.sv
module npbCtrl
  import npbPkg::*;
#(
  parameter int WAIT_W        = 4,
  parameter int NUM_RANGES    = 2,
  parameter int MIN_SIZE_LOG2 = 16,
  localparam int SEL_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output npbStrobe_t        strobe,
  output logic              busAle,
  output logic              busRd,
  output logic              busWr,
  output logic              rspReady,
  output logic              rspError
);
  localparam logic [31:0] WAIT_MASK = 32'(((1 << WAIT_W) - 1) << 4);
  localparam logic [31:0] CFG_MASK  = 32'hFFFF_1F03 | WAIT_MASK;
  localparam logic [31:0] CFG_RST   = WAIT_MASK;

  logic [31:0]            cfgReg [NUM_RANGES];
  logic [NUM_RANGES-1:0]  hitVec;
  logic                   anyHit;
  logic [SEL_W-1:0]       selIdx;

  npbState_e              state;
  logic                   curWide;
  logic                   curWrite;
  logic [WAIT_W-1:0]      curWait;
  logic [WAIT_W-1:0]      waitCnt;
  logic [1:0]             beat;
  logic                   errFlag;
  logic                   accept;
  logic [1:0]             lastBeat;

  // Window registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_RANGES; i++) cfgReg[i] <= CFG_RST;
    end else if (cfgWrEn) begin
      cfgReg[cfgSel] <= cfgWrData & CFG_MASK;
    end
  end

  assign cfgRdData = cfgReg[cfgSel];

  // Per-window address match
  for (genvar r = 0; r < NUM_RANGES; r++) begin : gRange
    logic [4:0]  sizeLog2;
    logic [31:0] mask;
    logic        unusedBits;
    assign sizeLog2 = (cfgReg[r][12:8] < 5'(MIN_SIZE_LOG2)) ? 5'(MIN_SIZE_LOG2) : cfgReg[r][12:8];
    assign mask     = ~((32'h1 << sizeLog2) - 32'h1);
    assign hitVec[r] = cfgReg[r][0] &&
                       ((reqAddr & mask) == ({cfgReg[r][31:16], 16'h0000} & mask));
    assign unusedBits = ^{cfgReg[r][3:2], cfgReg[r][15:13]};
  end

  // Lowest index wins
  always_comb begin
    anyHit = |hitVec;
    selIdx = '0;
    for (int i = NUM_RANGES - 1; i >= 0; i--) begin
      if (hitVec[i]) selIdx = SEL_W'(i);
    end
  end

  assign accept   = (state == ST_IDLE) && reqValid;
  assign lastBeat = curWide ? 2'd1 : 2'd3;

  // Beat sequencer and wait counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curWide  <= 1'b0;
      curWrite <= 1'b0;
      curWait  <= '0;
      waitCnt  <= '0;
      beat     <= '0;
      errFlag  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (anyHit) begin
              state    <= ST_ADDR;
              curWide  <= cfgReg[selIdx][1];
              curWait  <= cfgReg[selIdx][4 +: WAIT_W];
              curWrite <= reqWrite;
              beat     <= '0;
              errFlag  <= 1'b0;
            end else begin
              state   <= ST_RESP;
              errFlag <= 1'b1;
            end
          end
        end
        ST_ADDR: begin
          waitCnt <= '0;
          state   <= (curWait == '0) ? ST_DATA : ST_WAIT;
        end
        ST_WAIT: begin
          waitCnt <= waitCnt + 1'b1;
          if (waitCnt == WAIT_W'(curWait - 1'b1)) state <= ST_DATA;
        end
        ST_DATA: begin
          if (beat == lastBeat) begin
            state <= ST_RESP;
          end else begin
            beat  <= beat + 1'b1;
            state <= ST_ADDR;
          end
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Strobes to the datapath and bus control
  always_comb begin
    strobe.capture = accept && anyHit;
    strobe.ale     = (state == ST_ADDR);
    strobe.rd      = ((state == ST_WAIT) || (state == ST_DATA)) && !curWrite;
    strobe.wr      = ((state == ST_WAIT) || (state == ST_DATA)) && curWrite;
    strobe.dataPh  = (state == ST_DATA);
    strobe.wide    = curWide;
    strobe.beat    = beat;
  end

  assign busAle   = strobe.ale;
  assign busRd    = strobe.rd;
  assign busWr    = strobe.wr;
  assign rspReady = (state == ST_RESP);
  assign rspError = (state == ST_RESP) && errFlag;

  // R2: miss goes straight to an error response
  a_r2_miss_error: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !anyHit) |=> (rspReady && rspError));

  // R5: wait counter stays inside the window's wait count
  a_r5_wait_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (waitCnt < curWait));

  // R4: a 16-bit request never runs past two beats
  a_r4_wide_beats: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && curWide) |-> (beat <= 2'd1));

  // R5: after the last data cycle the response follows
  a_r5_resp_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && beat == lastBeat) |=> rspReady);
endmodule

// File: rtl/npbData.sv
module npbData
  import npbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  npbStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [BUS_W-1:0]  adIn,
  output logic [BUS_W-1:0]  adOut,
  output logic              adOe,
  output logic [2:0]        lowAddr,
  output logic [DATA_W-1:0] rspRData
);
  logic [ADDR_W-1:2] wordAddr;
  logic [DATA_W-1:0] wData;
  logic [DATA_W-1:0] rData;
  logic [1:0]        byteOff;
  logic [ADDR_W-1:0] beatAddr;
  logic [4:0]        laneSel;
  logic              unusedBits;

  assign unusedBits = ^reqAddr[1:0];

  // Byte offset within the word for the current beat
  assign byteOff  = strobe.wide ? {strobe.beat[0], 1'b0} : strobe.beat;
  assign beatAddr = {wordAddr, byteOff};
  assign laneSel  = strobe.wide ? {strobe.beat[0], 4'b0000} : {strobe.beat, 3'b000};
  assign lowAddr  = beatAddr[2:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddr <= '0;
      wData    <= '0;
      rData    <= '0;
    end else if (strobe.capture) begin
      wordAddr <= reqAddr[ADDR_W-1:2];
      wData    <= reqWData;
      rData    <= '0;
    end else if (strobe.dataPh && strobe.rd) begin
      if (strobe.wide) rData[laneSel +: 16] <= adIn;
      else             rData[laneSel +: 8]  <= adIn[7:0];
    end
  end

  // Line drive: address, then write data with address kept on idle lanes
  always_comb begin
    adOut = '0;
    if (strobe.ale) begin
      adOut = beatAddr[BUS_W-1:0];
    end else if (strobe.wr) begin
      if (strobe.wide) adOut = wData[laneSel +: 16];
      else             adOut = {beatAddr[15:8], wData[laneSel +: 8]};
    end
  end

  assign adOe     = strobe.ale || strobe.wr;
  assign rspRData = rData;
endmodule

// File: rtl/narrowPeriphBridge.sv
module narrowPeriphBridge
  import npbPkg::*;
#(
  parameter int WAIT_W        = 4,
  parameter int NUM_RANGES    = 2,
  parameter int MIN_SIZE_LOG2 = 16,
  localparam int SEL_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  output logic              rspReady,
  output logic              rspError,
  output logic [DATA_W-1:0] rspRData,
  output logic              busAle,
  output logic              busRd,
  output logic              busWr,
  output logic [2:0]        lowAddr,
  output logic [BUS_W-1:0]  adOut,
  output logic              adOe,
  input  logic [BUS_W-1:0]  adIn
);
  npbStrobe_t strobe;

  npbCtrl #(
    .WAIT_W(WAIT_W), .NUM_RANGES(NUM_RANGES), .MIN_SIZE_LOG2(MIN_SIZE_LOG2)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .strobe(strobe), .busAle(busAle), .busRd(busRd), .busWr(busWr),
    .rspReady(rspReady), .rspError(rspError)
  );

  npbData uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqAddr(reqAddr), .reqWData(reqWData), .adIn(adIn),
    .adOut(adOut), .adOe(adOe), .lowAddr(lowAddr), .rspRData(rspRData)
  );

  // R1: bus cycle kinds never overlap
  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busAle, busRd, busWr}));

  // R6: write cycles keep every line driven
  a_r6_write_driven: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> adOe);

  // R9: read cycles release the lines
  a_r9_read_released: assert property (@(posedge clk) disable iff (!rstN)
    busRd |-> !adOe);

  // R7: address cycle is driven and lasts one cycle
  a_r7_addr_driven: assert property (@(posedge clk) disable iff (!rstN)
    busAle |-> adOe);
  a_r5_ale_single: assert property (@(posedge clk) disable iff (!rstN)
    busAle |=> !busAle);
endmodule

// File: tb/tb_narrowPeriphBridge.sv
module tb_narrowPeriphBridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWData = '0;
  logic        rspReady, rspError;
  logic [31:0] rspRData;
  logic        busAle, busRd, busWr, adOe;
  logic [2:0]  lowAddr;
  logic [15:0] adOut, adIn;

  always #5 clk = ~clk;

  narrowPeriphBridge dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWData(reqWData),
    .rspReady(rspReady), .rspError(rspError), .rspRData(rspRData),
    .busAle(busAle), .busRd(busRd), .busWr(busWr), .lowAddr(lowAddr),
    .adOut(adOut), .adOe(adOe), .adIn(adIn)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Peripheral device model
  logic [7:0]  mem [0:4095];
  logic [15:0] latA = '0;
  bit          devWide = 0;
  logic [31:0] expBase = '0;

  always @(posedge clk) if (busAle) latA <= adOut;

  assign adIn = devWide ? {mem[{latA[11:1], 1'b1}], mem[{latA[11:1], 1'b0}]}
                        : {8'h00, mem[latA[11:0]]};

  // Scoreboard
  typedef struct {
    bit          err;
    bit          isRead;
    logic [31:0] data;
    int          beats;
    int          cycles;
  } expItem_t;
  expItem_t expQ[$];

  int aleCnt = 0;
  int busCyc = 0;
  bit prevBus = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (busAle) begin
        logic [15:0] eA;
        eA = expBase[15:0] + 16'(devWide ? aleCnt * 2 : aleCnt);
        check(adOut == eA, "R7 address cycle lines", {16'h0, adOut}, {16'h0, eA});
        check(adOe, "R7 address cycle drive", {31'h0, adOe}, 32'h1);
        check(lowAddr == eA[2:0], devWide ? "R4 low address step" : "R3 low address step",
              {29'h0, lowAddr}, {29'h0, eA[2:0]});
        aleCnt++;
      end
      if (busRd) check(!adOe, "R9 read lines released", {31'h0, adOe}, 32'h0);
      if (busWr) begin
        check(adOe, "R6 write lines driven", {31'h0, adOe}, 32'h1);
        if (devWide) begin
          mem[{latA[11:1], 1'b0}] = adOut[7:0];
          mem[{latA[11:1], 1'b1}] = adOut[15:8];
        end else begin
          check(adOut[15:8] == latA[15:8], "R6 upper lanes keep address",
                {24'h0, adOut[15:8]}, {24'h0, latA[15:8]});
          mem[latA[11:0]] = adOut[7:0];
        end
      end
      if (busAle || busRd || busWr) busCyc++;
      if (rspReady) begin
        if (expQ.size() == 0) begin
          check(0, "R5 unexpected response", 32'h1, 32'h0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(rspError == it.err, "R2 error flag", {31'h0, rspError}, {31'h0, it.err});
          if (it.isRead && !it.err)
            check(rspRData == it.data, "R9 read word assembly", rspRData, it.data);
          check(aleCnt == it.beats, it.err ? "R2 no bus cycles on miss" : "R3 R4 beat count",
                aleCnt, it.beats);
          check(busCyc == it.cycles, "R5 bus cycle count", busCyc, it.cycles);
          if (!it.err) check(prevBus, "R5 ready right after last beat", {31'h0, prevBus}, 32'h1);
        end
        aleCnt = 0;
        busCyc = 0;
      end
      prevBus = busAle || busRd || busWr;
    end
  end

  task automatic cfgWrite(input bit sel, input logic [31:0] val);
    @(negedge clk);
    cfgSel = sel; cfgWrData = val; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgCheck(input bit sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfgSel = sel;
    #1;
    check(cfgRdData == exp, tag, cfgRdData, exp);
  endtask

  task automatic access(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                        input bit wide, input int waits, input bit miss);
    expItem_t it;
    logic [11:0] a;
    a = {addr[11:2], 2'b00};
    it.err    = miss;
    it.isRead = !wr;
    it.data   = {mem[a + 12'd3], mem[a + 12'd2], mem[a + 12'd1], mem[a]};
    it.beats  = miss ? 0 : (wide ? 2 : 4);
    it.cycles = miss ? 0 : it.beats * (waits + 2);
    @(negedge clk);
    devWide = wide;
    expBase = {addr[31:2], 2'b00};
    expQ.push_back(it);
    reqWrite = wr; reqAddr = addr; reqWData = wd; reqValid = 1'b1;
    do @(negedge clk); while (!rspReady);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: reset state
    check(!busAle && !busRd && !busWr && !adOe && !rspReady, "R8 idle after reset",
          {27'h0, busAle, busRd, busWr, adOe, rspReady}, 32'h0);
    cfgCheck(0, 32'h0000_00F0, "R8 window 0 reset value");
    cfgCheck(1, 32'h0000_00F0, "R8 window 1 reset value");
    // R2: both disabled
    access(0, 32'h0000_0100, 0, 0, 0, 1);

    // R1: program windows, unused bits masked
    cfgWrite(0, 32'h0000_102D);
    cfgCheck(0, 32'h0000_1021, "R1 window 0 readback");
    cfgWrite(1, 32'h0001_1003);
    cfgCheck(1, 32'h0001_1003, "R1 window 1 readback");

    // R3 read, R4 read
    access(0, 32'h0000_0104, 0, 0, 2, 0);
    access(0, 32'h0001_0208, 0, 1, 0, 0);
    access(0, 32'h0000_0ABC, 0, 0, 2, 0);

    // R3 write, little-endian bytes
    access(1, 32'h0000_0300, 32'hA1B2C3D4, 0, 2, 0);
    check({mem[12'h303], mem[12'h302], mem[12'h301], mem[12'h300]} == 32'hA1B2C3D4,
          "R3 byte write order", {mem[12'h303], mem[12'h302], mem[12'h301], mem[12'h300]}, 32'hA1B2C3D4);
    access(0, 32'h0000_0300, 0, 0, 2, 0);

    // R4 write, halfword order
    access(1, 32'h0001_040C, 32'h11223344, 1, 0, 0);
    check({mem[12'h40F], mem[12'h40E], mem[12'h40D], mem[12'h40C]} == 32'h11223344,
          "R4 halfword write order", {mem[12'h40F], mem[12'h40E], mem[12'h40D], mem[12'h40C]}, 32'h11223344);
    access(0, 32'h0001_040C, 0, 1, 0, 0);

    // R2: outside both windows
    access(0, 32'h0002_0000, 0, 0, 0, 1);
    access(1, 32'hFFFF_0000, 32'h5555AAAA, 0, 0, 1);

    // R1: overlap, window 0 has priority
    cfgWrite(1, 32'h0000_1133);
    access(0, 32'h0000_0010, 0, 0, 2, 0);
    access(0, 32'h0001_0010, 0, 1, 3, 0);

    // R5: maximum wait count
    cfgWrite(0, 32'h0000_10F1);
    access(0, 32'h0000_0020, 0, 0, 15, 0);

    // R1: window 0 disabled, shared address falls to window 1
    cfgWrite(0, 32'h0000_0000);
    access(0, 32'h0000_0010, 0, 1, 3, 0);
    access(1, 32'h0000_0500, 32'hCAFE0123, 1, 3, 0);
    access(0, 32'h0000_0500, 0, 1, 3, 0);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R5 all responses seen", expQ.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule